// File: doc/BRIEF.md
# Parallel k-Winner Selector

This block takes a group of N unsigned (or, optionally, two's-complement) scores, each W bits wide, together with a selection count k. It flags each score that belongs among the k largest. The result is an N-bit mask in which bit i marks score i as a winner.

Every pair of scores is compared once. Each comparison yields a "greater" flag and an "equal" flag, and both flags are reused in the opposite sense for the partner score. Each score then counts how many other scores strictly exceed it. The score wins when that count is below k. Because the test is strict, scores that tie at the k-th place all win together, so the mask can carry more than k ones.

A sample is taken when the input strobe is high. The mask appears with its own valid flag exactly two clock cycles later, and a new sample may be presented on every cycle.

Top module: `kwta_select`

## Requirements
- R1: Bit i of `out_win` (score i at bits [i*W+W-1 : i*W] of `in_data`) is 1 exactly when fewer than k of the other scores are strictly greater than score i.
- R2: Equal scores never count against each other, so every score tied at the k-th place is flagged. For 1 <= k < N the mask holds at least k ones.
- R3: With k = 1 only the largest score is flagged, or all copies of it when the largest value is shared.
- R4: A selection count of 0 yields an all-zero mask.
- R5: A selection count of N or more yields an all-ones mask.
- R6: `out_valid` is high in the cycle exactly two clock edges after the edge that sampled `in_valid` high, and low two edges after a low strobe. Back-to-back samples are each accepted.
- R7: Data and k presented while `in_valid` is low are ignored, and `out_win` keeps its last value while `out_valid` is low.
- R8: With `SIGNED_IN` = 1 the scores are ordered as two's-complement numbers, so 0x10 outranks 0xF0.
- R9: After reset `out_valid` and `out_win` are 0.
- R10: With k >= 1 at least one score is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that samples `in_data` and `in_k` |
| in_data | input | N_IN*W_IN | Packed scores, score i at bits [i*W_IN +: W_IN] |
| in_k | input | $clog2(N_IN+1) | Selection count k |
| out_valid | output | 1 | Mask is valid this cycle |
| out_win | output | N_IN | Winner mask, bit i for score i |

## Verification
The assertions assume that reset stays deasserted across the two-cycle window that follows a sampled strobe. They also assume that `in_k` means nothing when the strobe is low. The stimulus releases reset once and never asserts it again. It draws k from 0 up to beyond N, so that the zero and saturating cases arise. Scores are often squeezed into a small value range, so that ties at the k-th place happen frequently rather than by chance. A second instance is built with signed ordering, and it receives the same samples with values of both signs.

// File: rtl/kwta_pkg.sv
package kwta_pkg;
   // Flat index of the unordered pair (a,b), a<b, among n scores.
   function automatic int pair_index(input int a, input int b, input int n);
      return a * n - (a * (a + 1)) / 2 + (b - a - 1);
   endfunction
endpackage

// File: rtl/kwta_pair_cmp.sv
module kwta_pair_cmp #(
   parameter int W_IN      = 8,
   parameter bit SIGNED_IN = 1'b0
) (
   input  logic [W_IN-1:0] a,
   input  logic [W_IN-1:0] b,
   output logic            a_gt_b,
   output logic            a_eq_b
);
   logic [W_IN-1:0] a_m;
   logic [W_IN-1:0] b_m;

   generate
      if (SIGNED_IN) begin : g_signed
         // Inverting the sign bit maps two's complement onto unsigned order.
         assign a_m = {~a[W_IN-1], a[W_IN-2:0]};
         assign b_m = {~b[W_IN-1], b[W_IN-2:0]};
      end else begin : g_unsigned
         assign a_m = a;
         assign b_m = b;
      end
   endgenerate

   assign a_gt_b = (a_m > b_m);
   assign a_eq_b = (a_m == b_m);
endmodule

// File: rtl/kwta_rank_thresh.sv
module kwta_rank_thresh #(
   parameter int N_IN = 8,
   parameter int KW   = 4
) (
   input  logic [N_IN-1:0] above,
   input  logic [KW-1:0]   k,
   output logic            win
);
   logic [KW-1:0] n_above;

   always_comb begin
      n_above = '0;
      for (int j = 0; j < N_IN; j++) begin
         n_above = n_above + KW'(above[j]);
      end
   end

   always_comb begin
      if (k == '0)
         win = 1'b0;
      else if (32'(k) >= N_IN)
         win = 1'b1;
      else
         win = (n_above < k);
   end
endmodule

// File: rtl/kwta_select.sv
module kwta_select #(
   parameter int N_IN      = 8,
   parameter int W_IN      = 8,
   parameter bit SIGNED_IN = 1'b0,
   localparam int KW       = $clog2(N_IN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [N_IN*W_IN-1:0] in_data,
   input  logic [KW-1:0]        in_k,
   output logic                 out_valid,
   output logic [N_IN-1:0]      out_win
);
   import kwta_pkg::*;

   localparam int NPAIR = N_IN * (N_IN - 1) / 2;

   generate
      if (N_IN < 2) begin : g_chk_n
         $error("kwta_select: N_IN must be at least 2");
      end
      if (W_IN < 2) begin : g_chk_w
         $error("kwta_select: W_IN must be at least 2");
      end
   endgenerate

   // Stage 0: one comparator per unordered pair.
   logic [NPAIR-1:0] gt_d;
   logic [NPAIR-1:0] eq_d;

   generate
      for (genvar a = 0; a < N_IN; a++) begin : g_row
         for (genvar b = a + 1; b < N_IN; b++) begin : g_col
            localparam int PI = pair_index(a, b, N_IN);
            kwta_pair_cmp #(.W_IN(W_IN), .SIGNED_IN(SIGNED_IN)) u_cmp (
               .a      (in_data[a*W_IN +: W_IN]),
               .b      (in_data[b*W_IN +: W_IN]),
               .a_gt_b (gt_d[PI]),
               .a_eq_b (eq_d[PI])
            );
         end
      end
   endgenerate

   // Stage 1 register: comparison results and k.
   logic [NPAIR-1:0] gt_q;
   logic [NPAIR-1:0] eq_q;
   logic [KW-1:0]    k_q;
   logic             v1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gt_q <= '0;
         eq_q <= '0;
         k_q  <= '0;
         v1_q <= 1'b0;
      end else begin
         v1_q <= in_valid;
         if (in_valid) begin
            gt_q <= gt_d;
            eq_q <= eq_d;
            k_q  <= in_k;
         end
      end
   end

   // Per-score vector of the partners that strictly exceed it.
   logic [N_IN-1:0] above [N_IN];

   always_comb begin
      for (int i = 0; i < N_IN; i++) begin
         for (int j = 0; j < N_IN; j++) begin
            if (j == i)
               above[i][j] = 1'b0;
            else if (j < i)
               above[i][j] = gt_q[pair_index(j, i, N_IN)];
            else
               above[i][j] = ~gt_q[pair_index(i, j, N_IN)] &
                             ~eq_q[pair_index(i, j, N_IN)];
         end
      end
   end

   logic [N_IN-1:0] win_d;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_thr
         kwta_rank_thresh #(.N_IN(N_IN), .KW(KW)) u_thr (
            .above (above[i]),
            .k     (k_q),
            .win   (win_d[i])
         );
      end
   endgenerate

   // Stage 2 register: winner mask.
   logic [N_IN-1:0] win_q;
   logic            v2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         v2_q  <= 1'b0;
      end else begin
         v2_q <= v1_q;
         if (v1_q) win_q <= win_d;
      end
   end

   assign out_valid = v2_q;
   assign out_win   = win_q;
endmodule

// File: rtl/kwta_select_chk.sv
module kwta_select_chk #(
   parameter int N_IN = 8,
   parameter int KW   = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [KW-1:0]   in_k,
   input logic            out_valid,
   input logic [N_IN-1:0] out_win
);
   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   p_zero_k_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_k == '0) |-> ##2 (out_win == '0));

   p_full_k_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && 32'(in_k) >= N_IN) |-> ##2 (out_win == '1));

   p_some_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_k != '0) |-> ##2 (out_win != '0));

   p_min_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_k != '0 && 32'(in_k) < N_IN)
         |-> ##2 ($countones(out_win) >= 32'($past(in_k, 2))));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_win));
endmodule

bind kwta_select kwta_select_chk #(.N_IN(N_IN), .KW(KW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_k      (in_k),
   .out_valid (out_valid),
   .out_win   (out_win)
);

// File: tb/sim_kwta_select.sv
module sim_kwta_select;
   localparam int CLK_P = 10;
   localparam int N     = 8;
   localparam int W     = 8;
   localparam int KW    = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [N*W-1:0] in_data = '0;
   logic [KW-1:0] in_k = '0;
   logic          ov_u, ov_s;
   logic [N-1:0]  ow_u, ow_s;

   int    total = 0;
   int    bad = 0;
   string phase = "R9";
   bit    live = 1'b0;
   bit    done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   kwta_select #(.N_IN(N), .W_IN(W), .SIGNED_IN(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_k(in_k), .out_valid(ov_u), .out_win(ow_u));

   kwta_select #(.N_IN(N), .W_IN(W), .SIGNED_IN(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_k(in_k), .out_valid(ov_s), .out_win(ow_s));

   // Rank rule of R1: winner when fewer than k scores are strictly larger.
   function automatic logic [N-1:0] ref_win(logic [N*W-1:0] d, int k, bit sgn);
      int v[N];
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         v[i] = int'(d[i*W +: W]);
         if (sgn && d[i*W+W-1]) v[i] = v[i] - (1 << W);
      end
      for (int i = 0; i < N; i++) begin
         int n_big = 0;
         for (int j = 0; j < N; j++) if (v[j] > v[i]) n_big++;
         r[i] = (n_big < k);
      end
      return r;
   endfunction

   // Two-cycle latency model (R6) with hold of the mask (R7).
   logic         mv1, mv2;
   logic [N-1:0] mu1, mu2, ms1, ms2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mv1 <= 1'b0; mv2 <= 1'b0;
         mu1 <= '0; mu2 <= '0; ms1 <= '0; ms2 <= '0;
      end else begin
         mv1 <= in_valid;
         if (in_valid) begin
            mu1 <= ref_win(in_data, int'(in_k), 1'b0);
            ms1 <= ref_win(in_data, int'(in_k), 1'b1);
         end
         mv2 <= mv1;
         if (mv1) begin
            mu2 <= mu1;
            ms2 <= ms1;
         end
      end
   end

   always @(negedge clk) begin
      if (live && !done) begin
         total++;
         if (ov_u !== mv2 || ow_u !== mu2) begin
            bad++;
            $display("FAIL %s unsigned: valid=%b win=%b expected valid=%b win=%b",
                     phase, ov_u, ow_u, mv2, mu2);
         end
         total++;
         if (ov_s !== mv2 || ow_s !== ms2) begin
            bad++;
            $display("FAIL %s signed: valid=%b win=%b expected valid=%b win=%b",
                     phase, ov_s, ow_s, mv2, ms2);
         end
      end
   end

   task automatic put(input logic v, input logic [N*W-1:0] d, input int k);
      @(negedge clk);
      #1;
      in_valid = v;
      in_data  = d;
      in_k     = KW'(k);
   endtask

   function automatic logic [N*W-1:0] rnd_data(input int span);
      logic [N*W-1:0] d;
      for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom_range(span - 1, 0));
      return d;
   endfunction

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      total++;
      if (ov_u !== 1'b0 || ow_u !== '0 || ov_s !== 1'b0 || ow_s !== '0) begin
         bad++;
         $display("FAIL R9 reset: valid=%b win=%b expected valid=0 win=0", ov_u, ow_u);
      end
      live = 1'b1;

      phase = "R3";
      put(1, {8'd5, 8'd3, 8'd90, 8'd1, 8'd7, 8'd2, 8'd4, 8'd6}, 1);
      put(1, {8'd90, 8'd3, 8'd90, 8'd1, 8'd7, 8'd2, 8'd90, 8'd6}, 1);
      put(0, '0, 0);
      put(0, '0, 0);

      phase = "R2";
      put(1, {8'd9, 8'd7, 8'd7, 8'd7, 8'd3, 8'd1, 8'd0, 8'd2}, 2);
      put(1, {8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4}, 3);
      put(1, {8'd1, 8'd2, 8'd3, 8'd4, 8'd4, 8'd6, 8'd7, 8'd8}, 4);

      phase = "R4";
      put(1, {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8}, 0);
      phase = "R5";
      put(1, {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8}, N);
      put(1, {8'd8, 8'd7, 8'd3, 8'd4, 8'd5, 8'd6, 8'd2, 8'd1}, N + 2);

      phase = "R8";
      put(1, {8'hF0, 8'h10, 8'h80, 8'h7F, 8'hFF, 8'h00, 8'h01, 8'hC0}, 1);
      put(1, {8'hF0, 8'h10, 8'h80, 8'h7F, 8'hFF, 8'h00, 8'h01, 8'hC0}, 3);

      phase = "R7";
      put(1, {8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80}, 2);
      for (int c = 0; c < 6; c++) put(0, rnd_data(256), $urandom_range(N, 0));

      phase = "R6";
      for (int c = 0; c < 200; c++) put(1, rnd_data(256), $urandom_range(N + 2, 0));

      phase = "R1";
      for (int c = 0; c < 300; c++)
         put(($urandom_range(3, 0) != 0), rnd_data((c % 2) ? 4 : 256),
             $urandom_range(N + 1, 0));

      phase = "R10";
      for (int c = 0; c < 100; c++) put(1, rnd_data(3), $urandom_range(N, 1));

      phase = "R7";
      for (int c = 0; c < 4; c++) put(0, rnd_data(256), 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule